// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This block watches the stream of retiring instructions of a processor core and compares each fetch address against a small set of programmable execute-breakpoint addresses. Every comparison that hits leaves a sticky flag in a status register. If the breakpoint that hit is enabled, the block raises a debug exception. Single-step retirement and an external task-switch trap also raise the exception. Matched execute breakpoints are reported in the same exception class as single-step.

Software reaches the block through an indexed register port with eight slots. Slots 0 to 3 hold the breakpoint addresses. Slot 6 is the status register and slot 7 is the control register. Slots 4 and 5 are reserved. The control register can also guard the register port: while its general-detect bit is set, any access to the port is refused. The refused access sets a status flag, clears the guard so a handler can get in, and raises the exception.

Top module: `dbg_bkpt_unit`

## Requirements
- R1: Slots 0 to 3 are writable and read back the breakpoint address. Slots 4 and 5 read as zero, and writes to them change nothing.
- R2: On a retiring instruction (`ret_valid` high) whose address equals breakpoint n, status bit n is set, whether or not breakpoint n is enabled.
- R3: Control bit 2n is the local enable and bit 2n+1 the global enable of breakpoint n. A hit on breakpoint n raises the exception only if either bit is set, so writing 0x1 to slot 7 arms breakpoint 0.
- R4: `exc_pulse` is high for exactly the cycle after each cycle that holds a qualifying event, and low otherwise. `exc_class` is 1 (debug) while the pulse is high and 0 (none) otherwise.
- R5: A retiring instruction with `step_en` high sets status bit 14 and raises the exception. Breakpoint status bits set in the same cycle remain set alongside it.
- R6: A high `task_trap` sets status bit 15 and raises the exception, whatever the control register holds.
- R7: While control bit 13 (general detect) is set, any access to the register port is refused. A refused write changes nothing, and a refused read returns 0. The refusal sets status bit 13, clears control bit 13 and raises the exception.
- R8: Status bits are sticky. Hardware only sets them. A software write to slot 6 replaces the status with the written value masked to 0xE00F, with hardware sets of the same cycle ORed in.
- R9: With `ret_valid` low, address matches and `step_en` have no effect on status or exception.
- R10: Several breakpoints hitting in one cycle set all their status bits and produce a single exception pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register port access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 3 | Register slot index |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data (combinational, current slot contents) |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_addr | input | 32 | Fetch address of the retiring instruction |
| step_en | input | 1 | Single-step mode active for the retiring instruction |
| task_trap | input | 1 | Task-switch trap request |
| exc_pulse | output | 1 | Debug exception, one cycle per event cycle |
| exc_class | output | 2 | Exception class: 1 debug, 0 none |

## Verification
A corrupted address or enable register shows up at the exception output one cycle after the first retirement at that address. The pulse is either missing or spurious. A status flag that is lost or wrongly set is invisible at the exception output. It appears only on the next read of slot 6, so the bench reads status right after each event. A stuck general-detect bit shows immediately on the next access: the read returns zero and an extra exception pulse follows.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

   localparam int IDX_W       = 3;
   localparam int SLOT_STATUS = 6;
   localparam int SLOT_CTRL   = 7;
   localparam int BIT_GDET    = 13;
   localparam int BIT_STEP    = 14;
   localparam int BIT_TASK    = 15;
   localparam int CLS_W       = 2;

   typedef enum logic [CLS_W-1:0] {
      EXC_NONE  = 2'd0,
      EXC_DEBUG = 2'd1
   } exc_class_e;

   function automatic logic [31:0] ctrl_mask_f(input int nbp);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < nbp; i++) begin
         m[2*i]   = 1'b1;
         m[2*i+1] = 1'b1;
      end
      m[BIT_GDET] = 1'b1;
      return m;
   endfunction

   function automatic logic [31:0] status_mask_f(input int nbp);
      logic [31:0] m;
      m = '0;
      for (int i = 0; i < nbp; i++) m[i] = 1'b1;
      m[BIT_GDET] = 1'b1;
      m[BIT_STEP] = 1'b1;
      m[BIT_TASK] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/dbg_bp_match.sv
module dbg_bp_match #(
   parameter int ADDR_W      = 32,
   parameter int IGNORE_LSBS = 0
) (
   input  logic [ADDR_W-1:0] cmp_addr,
   input  logic [ADDR_W-1:0] bp_addr,
   output logic              hit
);
   generate
      if (IGNORE_LSBS < 0 || IGNORE_LSBS >= ADDR_W) begin : g_bad
         $error("dbg_bp_match: IGNORE_LSBS out of range");
      end
      if (IGNORE_LSBS == 0) begin : g_full
         assign hit = (cmp_addr == bp_addr);
      end else begin : g_coarse
         assign hit = (cmp_addr[ADDR_W-1:IGNORE_LSBS] == bp_addr[ADDR_W-1:IGNORE_LSBS]);
      end
   endgenerate
endmodule

// File: rtl/dbg_regs.sv
module dbg_regs
   import dbg_pkg::*;
#(
   parameter int NUM_BP = 4,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         acc_valid,
   input  logic                         acc_write,
   input  logic [IDX_W-1:0]             acc_idx,
   input  logic [DATA_W-1:0]            acc_wdata,
   output logic [DATA_W-1:0]            acc_rdata,
   input  logic [NUM_BP-1:0]            set_hit,
   input  logic                         set_step,
   input  logic                         set_task,
   output logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr,
   output logic [NUM_BP-1:0]            bp_en,
   output logic [DATA_W-1:0]            status,
   output logic                         gd_hit
);
   localparam logic [31:0] CMASK32 = ctrl_mask_f(NUM_BP);
   localparam logic [31:0] SMASK32 = status_mask_f(NUM_BP);
   localparam logic [DATA_W-1:0] CMASK = CMASK32[DATA_W-1:0];
   localparam logic [DATA_W-1:0] SMASK = SMASK32[DATA_W-1:0];

   logic [NUM_BP-1:0][ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0]             ctrl_q;
   logic [DATA_W-1:0]             stat_q;
   logic [DATA_W-1:0]             stat_set;
   logic                          wr_ok;

   assign gd_hit = acc_valid && ctrl_q[BIT_GDET];
   assign wr_ok  = acc_valid && acc_write && !ctrl_q[BIT_GDET];

   always_comb begin
      stat_set = '0;
      stat_set[NUM_BP-1:0] = set_hit;
      stat_set[BIT_GDET]   = gd_hit;
      stat_set[BIT_STEP]   = set_step;
      stat_set[BIT_TASK]   = set_task;
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_BP; gi++) begin : g_addr
         always_ff @(posedge clk) begin
            if (!rst_n)
               addr_q[gi] <= '0;
            else if (wr_ok && acc_idx == IDX_W'(gi))
               addr_q[gi] <= acc_wdata[ADDR_W-1:0];
         end
         assign bp_en[gi] = ctrl_q[2*gi] | ctrl_q[2*gi+1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (gd_hit)
         ctrl_q[BIT_GDET] <= 1'b0;
      else if (wr_ok && acc_idx == IDX_W'(SLOT_CTRL))
         ctrl_q <= acc_wdata & CMASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         stat_q <= '0;
      else if (wr_ok && acc_idx == IDX_W'(SLOT_STATUS))
         stat_q <= (acc_wdata | stat_set) & SMASK;
      else
         stat_q <= (stat_q | stat_set) & SMASK;
   end

   always_comb begin
      acc_rdata = '0;
      if (!ctrl_q[BIT_GDET]) begin
         if (acc_idx == IDX_W'(SLOT_STATUS))
            acc_rdata = stat_q;
         else if (acc_idx == IDX_W'(SLOT_CTRL))
            acc_rdata = ctrl_q;
         else
            for (int i = 0; i < NUM_BP; i++)
               if (acc_idx == IDX_W'(i))
                  acc_rdata = DATA_W'(addr_q[i]);
      end
   end

   assign bp_addr = addr_q;
   assign status  = stat_q;

   // R7: a refused access clears general detect and leaves BD set
   a_r7_gd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      gd_hit |=> (!ctrl_q[BIT_GDET] && stat_q[BIT_GDET]));

   // R8: without a software write to status no bit ever drops
   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_ok && acc_idx == IDX_W'(SLOT_STATUS)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

   // R7: a refused write leaves every address register unchanged
   a_r7_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      (gd_hit && acc_write) |=> $stable(addr_q));
endmodule

// File: rtl/dbg_exc_gen.sv
module dbg_exc_gen
   import dbg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             raise,
   output logic             exc_pulse,
   output logic [CLS_W-1:0] exc_class
);
   logic       pulse_q;
   exc_class_e cls_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         cls_q   <= EXC_NONE;
      end else begin
         pulse_q <= raise;
         cls_q   <= raise ? EXC_DEBUG : EXC_NONE;
      end
   end

   assign exc_pulse = pulse_q;
   assign exc_class = cls_q;

   // R4: the pulse follows a qualifying cycle by exactly one cycle
   a_r4_pulse_follows: assert property (@(posedge clk) disable iff (!rst_n)
      raise |=> exc_pulse);
   a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !raise |=> !exc_pulse);
endmodule

// File: rtl/dbg_bkpt_unit.sv
module dbg_bkpt_unit
   import dbg_pkg::*;
#(
   parameter int NUM_BP      = 4,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int IGNORE_LSBS = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [2:0]        acc_idx,
   input  logic [31:0]       acc_wdata,
   output logic [31:0]       acc_rdata,
   input  logic              ret_valid,
   input  logic [31:0]       ret_addr,
   input  logic              step_en,
   input  logic              task_trap,
   output logic              exc_pulse,
   output logic [1:0]        exc_class
);
   generate
      if (NUM_BP < 1 || NUM_BP > 4) begin : g_chk_nbp
         $error("dbg_bkpt_unit: NUM_BP must be 1..4");
      end
      if (DATA_W != 32 || ADDR_W > DATA_W) begin : g_chk_w
         $error("dbg_bkpt_unit: DATA_W must be 32 and ADDR_W <= DATA_W");
      end
   endgenerate

   logic [NUM_BP-1:0][ADDR_W-1:0] bp_addr;
   logic [NUM_BP-1:0]             bp_en;
   logic [NUM_BP-1:0]             raw_hit;
   logic [NUM_BP-1:0]             ret_hit;
   logic [DATA_W-1:0]             status;
   logic                          gd_hit;
   logic                          step_hit;
   logic                          raise;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_BP; gi++) begin : g_bp
         dbg_bp_match #(.ADDR_W(ADDR_W), .IGNORE_LSBS(IGNORE_LSBS)) u_match (
            .cmp_addr (ret_addr[ADDR_W-1:0]),
            .bp_addr  (bp_addr[gi]),
            .hit      (raw_hit[gi])
         );
         assign ret_hit[gi] = ret_valid && raw_hit[gi];

         // R2: a hit marks status even for a disabled breakpoint
         a_r2_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
            ret_hit[gi] |=> status[gi]);
      end
   endgenerate

   assign step_hit = ret_valid && step_en;
   assign raise    = (|(ret_hit & bp_en)) || step_hit || task_trap || gd_hit;

   dbg_regs #(.NUM_BP(NUM_BP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_idx   (acc_idx),
      .acc_wdata (acc_wdata),
      .acc_rdata (acc_rdata),
      .set_hit   (ret_hit),
      .set_step  (step_hit),
      .set_task  (task_trap),
      .bp_addr   (bp_addr),
      .bp_en     (bp_en),
      .status    (status),
      .gd_hit    (gd_hit)
   );

   dbg_exc_gen u_exc (
      .clk       (clk),
      .rst_n     (rst_n),
      .raise     (raise),
      .exc_pulse (exc_pulse),
      .exc_class (exc_class)
   );

   // R4: class code tracks the pulse
   a_r4_class: assert property (@(posedge clk) disable iff (!rst_n)
      exc_pulse ? (exc_class == 2'd1) : (exc_class == 2'd0));

   // R5: single-step retirement raises the exception and sets BS
   a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
      step_hit |=> (exc_pulse && status[BIT_STEP]));

   // R6: task trap needs no enable
   a_r6_task: assert property (@(posedge clk) disable iff (!rst_n)
      task_trap |=> (exc_pulse && status[BIT_TASK]));
endmodule

// File: tb/tb_dbg_bkpt_unit.sv
module tb_dbg_bkpt_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [2:0]  acc_idx = '0;
   logic [31:0] acc_wdata = '0;
   logic [31:0] acc_rdata;
   logic        ret_valid = 1'b0;
   logic [31:0] ret_addr = '0;
   logic        step_en = 1'b0, task_trap = 1'b0;
   logic        exc_pulse;
   logic [1:0]  exc_class;

   int n_run = 0, n_fail = 0;

   typedef struct { bit exp; string tag; } item_t;
   item_t q[$];

   always #5 clk = ~clk;

   dbg_bkpt_unit dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .ret_valid(ret_valid), .ret_addr(ret_addr),
      .step_en(step_en), .task_trap(task_trap),
      .exc_pulse(exc_pulse), .exc_class(exc_class)
   );

   // monitor: compares pulse and class just after each edge
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         n_run++;
         if (exc_pulse !== it.exp || exc_class !== (it.exp ? 2'd1 : 2'd0)) begin
            n_fail++;
            $display("FAIL %s: pulse/class actual %0b/%0d expected %0b/%0d",
                     it.tag, exc_pulse, exc_class, it.exp, it.exp ? 1 : 0);
         end
      end
   end

   task automatic cyc(input bit rv, input logic [31:0] ra, input bit se, input bit tt,
                      input bit av, input bit aw, input logic [2:0] ai,
                      input logic [31:0] wd, input bit exp, input string tag);
      item_t it;
      @(negedge clk);
      ret_valid = rv; ret_addr = ra; step_en = se; task_trap = tt;
      acc_valid = av; acc_write = aw; acc_idx = ai; acc_wdata = wd;
      it.exp = exp; it.tag = tag;
      q.push_back(it);
      @(posedge clk);
   endtask

   task automatic wr(input logic [2:0] ai, input logic [31:0] wd, input bit exp, input string tag);
      cyc(0, 0, 0, 0, 1, 1, ai, wd, exp, tag);
   endtask

   task automatic rd(input logic [2:0] ai, input logic [31:0] ev, input bit exp, input string tag);
      item_t it;
      @(negedge clk);
      ret_valid = 0; step_en = 0; task_trap = 0;
      acc_valid = 1; acc_write = 0; acc_idx = ai; acc_wdata = 0;
      it.exp = exp; it.tag = tag;
      q.push_back(it);
      #1;
      n_run++;
      if (acc_rdata !== ev) begin
         n_fail++;
         $display("FAIL %s: slot %0d read actual %h expected %h", tag, ai, acc_rdata, ev);
      end
      @(posedge clk);
   endtask

   task automatic ret(input logic [31:0] ra, input bit se, input bit exp, input string tag);
      cyc(1, ra, se, 0, 0, 0, 0, 0, exp, tag);
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 idle");
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // reset state
      rd(0, 32'h0, 0, "R1 reset addr");
      rd(6, 32'h0, 0, "R8 reset status");
      rd(7, 32'h0, 0, "R3 reset ctrl");
      // R1 address slots and reserved slots
      wr(0, 32'h1000, 0, "R1"); wr(1, 32'h2000, 0, "R1");
      wr(2, 32'h3000, 0, "R1"); wr(3, 32'h4000, 0, "R1");
      wr(4, 32'hFFFF, 0, "R1"); wr(5, 32'h1234, 0, "R1");
      rd(0, 32'h1000, 0, "R1 slot0"); rd(3, 32'h4000, 0, "R1 slot3");
      rd(4, 32'h0, 0, "R1 reserved4"); rd(5, 32'h0, 0, "R1 reserved5");
      rd(2, 32'h3000, 0, "R1 slot2 after reserved write");
      // R2 disabled breakpoint still flags status
      ret(32'h1000, 0, 0, "R2 disabled hit no exc");
      rd(6, 32'h1, 0, "R2 status bit0");
      // R8 software clear
      wr(6, 32'h0, 0, "R8"); rd(6, 32'h0, 0, "R8 cleared");
      // R3 local enable of bp0 via 0x1
      wr(7, 32'h1, 0, "R3");
      ret(32'h1000, 0, 1, "R3 bp0 armed");
      ret(32'h5000, 0, 0, "R4 miss no exc");
      rd(6, 32'h1, 0, "R8 sticky after miss");
      // R3 global enable of bp3
      wr(6, 32'h0, 0, "R8"); wr(7, 32'h80, 0, "R3");
      ret(32'h4000, 0, 1, "R3 bp3 global");
      ret(32'h2000, 0, 0, "R2 bp1 disabled");
      ret(32'h4000, 0, 1, "R4 back-to-back");
      rd(6, 32'hA, 0, "R2 status bits 1 and 3");
      // R9 no retirement
      wr(6, 32'h0, 0, "R8");
      cyc(0, 32'h4000, 1, 0, 0, 0, 0, 0, 0, "R9 no retire");
      rd(6, 32'h0, 0, "R9 status untouched");
      // R5 single step coexisting with bp3
      ret(32'h4000, 1, 1, "R5 step+bp");
      rd(6, 32'h4008, 0, "R5 BS with B3");
      ret(32'h7000, 1, 1, "R5 step alone");
      // R6 task trap with control cleared
      wr(6, 32'h0, 0, "R8"); wr(7, 32'h0, 0, "R6");
      cyc(0, 0, 0, 1, 0, 0, 0, 0, 1, "R6 task trap");
      rd(6, 32'h8000, 0, "R6 BT set");
      // R7 general detect, refused write
      wr(6, 32'h0, 0, "R8"); wr(7, 32'h2001, 0, "R7");
      wr(0, 32'h9999, 1, "R7 refused write");
      rd(7, 32'h1, 0, "R7 GD cleared");
      rd(0, 32'h1000, 0, "R7 addr unchanged");
      rd(6, 32'h2000, 0, "R7 BD set");
      // R7 refused read
      wr(7, 32'h2001, 0, "R7");
      rd(0, 32'h0, 1, "R7 refused read");
      rd(0, 32'h1000, 0, "R7 read after unlock");
      // R8 masked write
      wr(6, 32'hFFFF_FFFF, 0, "R8");
      rd(6, 32'hE00F, 0, "R8 mask");
      // R10 two breakpoints on one address
      wr(6, 32'h0, 0, "R8"); wr(1, 32'h1000, 0, "R10"); wr(7, 32'h5, 0, "R10");
      ret(32'h1000, 0, 1, "R10 double hit one pulse");
      idle();
      rd(6, 32'h3, 0, "R10 both bits");
      idle(); idle();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule